// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters. It watches the idle-high line for a falling edge. It then checks the start bit at its middle and samples each following bit at its centre. Timing comes from a tick input that pulses once per sixteenth of a bit period, and the block counts these ticks.

The word length, parity enable, parity sense and forced parity come from the same six-bit format word that drives the matching transmitter, so the bit positions of that word are fixed. The word is captured when a start bit is confirmed and held for the rest of the character. For each character the block gives one valid pulse, together with the byte (zero-extended for short words) and flags for parity error, framing error and break. Buffering, interrupts and the generation of the baud tick are left to neighbouring blocks.

Top module: `uart_rx_line`

## Requirements
- R1: Format bits [1:0] set the number of data bits (00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8). Data bits are taken least significant first. Unused upper bits of `rx_data` read as 0.
- R2: With format bit 3 at 0, no parity bit is taken, the stop bit directly follows the data, and `parity_err` is 0.
- R3: With bit 3 at 1 and bit 5 at 0, bit 4 at 0 expects odd parity and bit 4 at 1 expects even parity over the data bits plus the parity bit. A mismatch sets `parity_err`.
- R4: With bits 3 and 5 at 1, the parity bit must be 1 when bit 4 is 0, and 0 when bit 4 is 1. Otherwise `parity_err` is set.
- R5: The first stop bit is sampled at its middle. If it is low, `frame_err` is set.
- R6: If every data bit, the parity bit (when enabled) and the stop bit are sampled low, `break_det` and `frame_err` are set and `rx_data` is 0. No further character is reported until the line has returned high.
- R7: A low pulse on the line that is high again at the eighth tick after the falling edge produces no character.
- R8: `rx_valid` is high for exactly one clock per character, together with that character's data and flags. After reset, `rx_valid`, `rx_data` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-clock pulse at 16 times the bit rate |
| line_cfg | input | 6 | Format word: [1:0] length, [2] stop count (unused here), [3] parity on, [4] sense, [5] force |
| rx_line | input | 1 | Serial input, idle high |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | One-clock strobe for a new character |
| parity_err | output | 1 | Parity mismatch for this character |
| frame_err | output | 1 | Stop bit sampled low |
| break_det | output | 1 | Whole character sampled low |

## Verification
The stimulus table covers every word length, the case with no parity, and both senses of computed parity and of forced parity. Each parity mode is sent once with a correct parity bit and once with a wrong one, which shows that the check follows the format bits and not one fixed rule. An all-zero character with a good stop bit is separated from a real break, and a character whose only fault is a low stop bit shows a framing error on its own. Directed runs send a short start glitch and a held-low break, then a clean character after each, to show that the receiver recovers.

// File: rtl/uart_rx_line.sv
module uart_rx_line #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [5:0] line_cfg,
  input  logic       rx_line,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       parity_err,
  output logic       frame_err,
  output logic       break_det
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;
  st_t st;

  logic [1:0]    sync;
  logic          rx_s, rx_d;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shf;
  logic          seen_hi, pbit;
  logic [1:0]    len_q;
  logic          pen_q, sense_q, force_q;
  logic          unused_stop_cfg;

  assign unused_stop_cfg = line_cfg[2];
  assign rx_s = sync[1];

  wire       at_mid   = tick16 && (cnt == CW'(OSR - 1));
  wire       at_half  = tick16 && (cnt == CW'(HALF - 1));
  wire [2:0] last_idx = 3'd4 + {1'b0, len_q};
  wire       dpar     = ^shf;
  wire       exp_p    = force_q ? ~sense_q : (sense_q ? dpar : ~dpar);
  wire       all_low  = !rx_s && !seen_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      rx_d <= 1'b1;
    end else begin
      sync <= {sync[0], rx_line};
      rx_d <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      idx        <= '0;
      shf        <= '0;
      seen_hi    <= 1'b0;
      pbit       <= 1'b0;
      len_q      <= '0;
      pen_q      <= 1'b0;
      sense_q    <= 1'b0;
      force_q    <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      break_det  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (rx_d && !rx_s) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick16) begin
          cnt <= cnt + 1'b1;
          if (at_half) begin
            if (rx_s) st <= S_IDLE;
            else begin
              st      <= S_DATA;
              cnt     <= '0;
              idx     <= '0;
              shf     <= '0;
              seen_hi <= 1'b0;
              len_q   <= line_cfg[1:0];
              pen_q   <= line_cfg[3];
              sense_q <= line_cfg[4];
              force_q <= line_cfg[5];
            end
          end
        end
        S_DATA: if (tick16) begin
          cnt <= cnt + 1'b1;
          if (at_mid) begin
            cnt      <= '0;
            shf[idx] <= rx_s;
            seen_hi  <= seen_hi | rx_s;
            idx      <= idx + 3'd1;
            if (idx == last_idx) st <= pen_q ? S_PAR : S_STOP;
          end
        end
        S_PAR: if (tick16) begin
          cnt <= cnt + 1'b1;
          if (at_mid) begin
            cnt     <= '0;
            pbit    <= rx_s;
            seen_hi <= seen_hi | rx_s;
            st      <= S_STOP;
          end
        end
        S_STOP: if (tick16) begin
          cnt <= cnt + 1'b1;
          if (at_mid) begin
            cnt        <= '0;
            rx_valid   <= 1'b1;
            rx_data    <= shf;
            parity_err <= pen_q && (pbit != exp_p);
            frame_err  <= !rx_s;
            break_det  <= all_low;
            st         <= all_low ? S_BRK : S_IDLE;
          end
        end
        S_BRK: if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module uart_rx_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       parity_err,
  input logic       frame_err,
  input logic       break_det,
  input logic       pen_q,
  input logic [1:0] len_q
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R8
  AST_BREAK_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && break_det) |-> frame_err); // R6
  AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && break_det) |-> (rx_data == 8'h00)); // R6
  AST_NO_PARITY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !pen_q) |-> !parity_err); // R2
  AST_SHORT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && len_q == 2'b00) |-> (rx_data[7:5] == 3'b000)); // R1
endmodule

bind uart_rx_line uart_rx_line_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .parity_err(parity_err), .frame_err(frame_err), .break_det(break_det),
  .pen_q(pen_q), .len_q(len_q)
);

// File: tb/uart_rx_line_tb.sv
`timescale 1ns/1ps
module uart_rx_line_tb;
  localparam int BIT = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [5:0] line_cfg = 6'h03;
  logic       rx_line = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, parity_err, frame_err, break_det;

  int tests = 0;
  int fails = 0;
  int vcnt  = 0;
  logic [7:0] cap_d;
  logic cap_pe, cap_fe, cap_bk;
  logic [1:0] tdiv = '0;

  uart_rx_line u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_cfg(line_cfg), .rx_line(rx_line),
    .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
    .frame_err(frame_err), .break_det(break_det)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
    if (rst_n && rx_valid) begin
      vcnt   <= vcnt + 1;
      cap_d  <= rx_data;
      cap_pe <= parity_err;
      cap_fe <= frame_err;
      cap_bk <= break_det;
    end
  end

  // {cfg, data, parity bit sent, stop bit sent, expected data, expected pe, expected fe}
  localparam logic [25:0] VEC [15] = '{
    {6'h03, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0},
    {6'h0B, 8'hA5, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0},
    {6'h0B, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0},
    {6'h1B, 8'h07, 1'b1, 1'b1, 8'h07, 1'b0, 1'b0},
    {6'h1B, 8'h07, 1'b0, 1'b1, 8'h07, 1'b1, 1'b0},
    {6'h00, 8'hFF, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0},
    {6'h01, 8'hEA, 1'b0, 1'b1, 8'h2A, 1'b0, 1'b0},
    {6'h0A, 8'h7F, 1'b0, 1'b1, 8'h7F, 1'b0, 1'b0},
    {6'h2B, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0},
    {6'h2B, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0},
    {6'h3B, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0},
    {6'h3B, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0},
    {6'h03, 8'h55, 1'b0, 1'b0, 8'h55, 1'b0, 1'b1},
    {6'h18, 8'h13, 1'b1, 1'b1, 8'h13, 1'b0, 1'b0},
    {6'h0B, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] c, input logic [7:0] d, input logic p, input logic stp);
    line_cfg = c;
    rx_line = 1'b0;
    wait_clk(BIT);
    for (int i = 0; i < 5 + int'(c[1:0]); i++) begin
      rx_line = d[i];
      wait_clk(BIT);
    end
    if (c[3]) begin
      rx_line = p;
      wait_clk(BIT);
    end
    rx_line = stp;
    wait_clk(BIT);
    rx_line = 1'b1;
    wait_clk(2 * BIT);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    // R8 reset state
    check(!rx_valid && rx_data == 0 && !parity_err && !frame_err && !break_det,
          "R8 reset", {rx_valid, rx_data, parity_err, frame_err, break_det}, 0);
    wait_clk(BIT);

    for (int i = 0; i < 15; i++) begin
      base = vcnt;
      send(VEC[i][25:20], VEC[i][19:12], VEC[i][11], VEC[i][10]);
      check(vcnt == base + 1, "R8 one strobe", vcnt - base, 1);
      check(cap_d == VEC[i][9:2], "R1 data", cap_d, VEC[i][9:2]);
      check(cap_pe == VEC[i][1], "R2/R3/R4 parity", cap_pe, VEC[i][1]);
      check(cap_fe == VEC[i][0], "R5 framing", cap_fe, VEC[i][0]);
      check(!cap_bk, "R6 no break", cap_bk, 0);
    end

    // R7 glitch shorter than half a bit
    base = vcnt;
    rx_line = 1'b0;
    wait_clk(12);
    rx_line = 1'b1;
    wait_clk(3 * BIT);
    check(vcnt == base, "R7 glitch ignored", vcnt - base, 0);
    send(6'h03, 8'hC3, 1'b0, 1'b1);
    check(vcnt == base + 1 && cap_d == 8'hC3, "R7 recover", cap_d, 8'hC3);

    // R6 break held low for many character times
    base = vcnt;
    line_cfg = 6'h0B;
    rx_line = 1'b0;
    wait_clk(13 * BIT);
    check(vcnt == base + 1, "R6 single report", vcnt - base, 1);
    check(cap_bk && cap_fe, "R6 break+frame", {cap_bk, cap_fe}, 2'b11);
    check(cap_d == 8'h00, "R6 data zero", cap_d, 0);
    rx_line = 1'b1;
    wait_clk(2 * BIT);
    check(vcnt == base + 1, "R6 no restart", vcnt - base, 1);
    send(6'h03, 8'h5A, 1'b0, 1'b1);
    check(cap_d == 8'h5A && !cap_bk && !cap_fe, "R6 after break", cap_d, 8'h5A);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule